// File: doc/BRIEF.md
# Grouped Priority Interrupt Resolver

This block arbitrates among one group of eight interrupt sources and hands the core a single vector number for the winner. The arbitration order is not tied to the source index. It comes from a slot register with eight 3-bit fields. Each field belongs to one priority position and holds the 3-bit code of the group member that occupies that position. A separate 7-bit override field can raise any one source above every slot. A per-source enable register qualifies the raw request lines, so only requests that are both pending and enabled take part.

Source n of the group is reported as vector `VEC_BASE + n`. Vector 0 is reserved and means that no interrupt is pending. The vector is resolved combinationally from the current registers and request lines. It appears both on a dedicated output and in a read-only register. A request line to the core follows it. Software configures the block through a small synchronous register bus. The bus has a whole-register write for the slot register, a per-position slot update command that rejects positions above 7, an enable register, and a configuration register that holds the override.

Top module: `gpir_top`

## Requirements
- R1: After a synchronous active-low reset, position k of the slot register holds code k, every source is disabled, the override field is 0, the vector reads 0 and `irq_o` is low.
- R2: Bus address 0 reads and writes the slot register. The 3-bit field of position p (0 to 3) sits at bit 20 + (3 - p) * 3, and the field of position p (4 to 7) sits at bit 4 + (7 - p) * 3. All other bits read as 0.
- R3: Bus address 2 is the enable register. Bit (31 - n) enables source n, and bits 23:0 read as 0. A request from a disabled source never produces a vector.
- R4: Among sources that are both requesting and enabled, the one whose code stands in the lowest-numbered position wins. Position 0 is the highest. The vector is `VEC_BASE` plus that code.
- R5: When a code appears in more than one position, only its earliest position counts. A source whose code appears in no position is never chosen through the slots.
- R6: Bus address 1 holds the override in bits 30:24, and its other bits read as 0. When the override equals `VEC_BASE + n` and source n is requesting and enabled, the vector is the override value, regardless of the slots. Otherwise the override has no effect.
- R7: Bus address 3 returns the resolved vector in bits 6:0, with upper bits 0. The value 0 means nothing is pending. The vector follows request and register changes with no added clock delay.
- R8: `irq_o` is high exactly when the resolved vector is non-zero.
- R9: A write to bus address 4 is a slot update command. The position is in wdata[3:0] and the code is in wdata[10:8]. A position of 0 to 7 replaces that single field. A position of 8 or more leaves the slot register unchanged.
- R10: A write to bus address 3 changes no register and does not change the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 8 | Pending request of each group source, bit n = source n |
| bus_addr_i | input | 3 | Register address |
| bus_wen_i | input | 1 | Write strobe, register updated at the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| vec_o | output | 7 | Resolved vector, 0 when nothing is pending |
| irq_o | output | 1 | Request to the core |

## Verification
Two things can fall in the same cycle. One is the override contending with a slot-based winner. The other is a slot or enable write landing while requests are already pending. The override case is provoked by table rows in which the override source and a higher-positioned slot source request together, with the override source once enabled and once disabled. For the write case, the bench holds requests steady while it rewrites the slot order. It judges that the vector keeps the old winner up to the rising edge and shows the new winner in the cycle after it.

// File: rtl/gpir_pkg.sv
// Package: shared constants, slot geometry and the bus address map of
// the grouped priority interrupt resolver.
// Assumes a fixed group of eight sources with 3-bit codes and a 7-bit vector.
package gpir_pkg;

    localparam int NSRC        = 8;
    localparam int CODE_W      = 3;
    localparam int REG_W       = 32;
    localparam int VEC_W       = 7;
    localparam int POS_W       = 4;
    localparam int CMD_CODE_LO = 8;
    localparam int OVR_LO      = 24;

    typedef logic [NSRC-1:0][CODE_W-1:0] slot_arr_t;

    typedef enum logic [2:0] {
        A_SLOT = 3'd0,
        A_CFG  = 3'd1,
        A_MASK = 3'd2,
        A_VEC  = 3'd3,
        A_SET  = 3'd4
    } grp_addr_e;

    // Bit offset of the code field of a priority position.
    function automatic int slot_lsb(input int pos);
        return (pos < 4) ? (20 + (3 - pos) * 3) : (4 + (7 - pos) * 3);
    endfunction

    // Reset order: position k holds code k.
    function automatic slot_arr_t ident_slots();
        slot_arr_t r;
        for (int k = 0; k < NSRC; k++) r[k] = CODE_W'(k);
        return r;
    endfunction

endpackage

// File: rtl/gpir_regs.sv
// Module: configuration storage of the resolver (slot codes, source
// enables, override source). Writes take effect at the rising edge.
// Assumes a single-beat write bus; reads are assembled by the parent.
module gpir_regs
    import gpir_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wen_i,
    input  logic [2:0]           addr_i,
    input  logic [REG_W-1:0]     wdata_i,
    output slot_arr_t            slot_q,
    output logic [NSRC-1:0]      en_q,
    output logic [VEC_W-1:0]     ovr_q
);

    localparam slot_arr_t IDENT = ident_slots();

    logic [POS_W-1:0]  cmd_pos;
    logic [CODE_W-1:0] cmd_code;
    logic              cmd_ok;

    // Decode the fields of a slot update command.
    always_comb begin
        cmd_pos  = wdata_i[POS_W-1:0];
        cmd_code = wdata_i[CMD_CODE_LO +: CODE_W];
        cmd_ok   = (cmd_pos < POS_W'(NSRC));
    end

    // Register update on reset or bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= IDENT;
            en_q   <= '0;
            ovr_q  <= '0;
        end else if (wen_i) begin
            case (grp_addr_e'(addr_i))
                A_SLOT: for (int p = 0; p < NSRC; p++)
                            slot_q[p] <= wdata_i[slot_lsb(p) +: CODE_W];
                A_CFG:  ovr_q <= wdata_i[OVR_LO +: VEC_W];
                A_MASK: for (int n = 0; n < NSRC; n++)
                            en_q[n] <= wdata_i[REG_W-1-n];
                A_SET:  if (cmd_ok) slot_q[cmd_pos[CODE_W-1:0]] <= cmd_code;
                default: ;
            endcase
        end
    end

    // R1: reset loads identity order, clears enables and override.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (slot_q == IDENT) && (en_q == '0) && (ovr_q == '0));

    // R9: a command with a position of 8 or more leaves the slots alone.
    a_r9_bad_position_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && addr_i == A_SET && wdata_i[POS_W-1:0] >= POS_W'(NSRC))
        |=> $stable(slot_q));

    // R10: writes to the vector address touch no register.
    a_r10_vec_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && addr_i == A_VEC) |=> $stable(slot_q) && $stable(en_q) && $stable(ovr_q));

endmodule

// File: rtl/gpir_select.sv
// Module: combinational winner selection. It walks the priority positions
// in order, skips codes already seen in an earlier position, and lets a
// matching active override source pre-empt the slot winner.
// Assumes VEC_BASE >= 1 and VEC_BASE + NSRC - 1 <= 127.
module gpir_select
    import gpir_pkg::*;
#(
    parameter int VEC_BASE = 32
) (
    input  slot_arr_t            slot_i,
    input  logic [NSRC-1:0]      active_i,
    input  logic [VEC_W-1:0]     ovr_i,
    output logic [VEC_W-1:0]     vec_o
);

    localparam logic [VEC_W-1:0] BASE = VEC_W'(VEC_BASE);

    logic [NSRC-1:0]   seen;
    logic              found;
    logic [CODE_W-1:0] win_code;
    logic [VEC_W-1:0]  ovr_off;
    logic              ovr_hit;

    // Priority walk over positions, first unique active code wins.
    always_comb begin
        seen     = '0;
        found    = 1'b0;
        win_code = '0;
        for (int p = 0; p < NSRC; p++) begin
            if (!found && !seen[slot_i[p]] && active_i[slot_i[p]]) begin
                found    = 1'b1;
                win_code = slot_i[p];
            end
            seen[slot_i[p]] = 1'b1;
        end
    end

    // Override match: source inside the group and currently active.
    always_comb begin
        ovr_off = ovr_i - BASE;
        ovr_hit = (ovr_i >= BASE) && (ovr_off < VEC_W'(NSRC))
                  && active_i[ovr_off[CODE_W-1:0]];
    end

    // Final vector: override, then slot winner, else none.
    always_comb begin
        if (ovr_hit)    vec_o = ovr_i;
        else if (found) vec_o = BASE + VEC_W'(win_code);
        else            vec_o = '0;
    end

endmodule

// File: rtl/gpir_top.sv
// Module: top of the grouped priority interrupt resolver. Qualifies the
// requests with the enables, resolves the vector, drives the core
// request and the read mux of the register bus.
// Assumes synchronous active-low reset and a combinational read path.
module gpir_top
    import gpir_pkg::*;
#(
    parameter int VEC_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        src_req_i,
    input  logic [2:0]        bus_addr_i,
    input  logic              bus_wen_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [6:0]        vec_o,
    output logic              irq_o
);

    localparam logic [VEC_W-1:0] BASE = VEC_W'(VEC_BASE);

    slot_arr_t        slot_q;
    logic [NSRC-1:0]  en_q;
    logic [VEC_W-1:0] ovr_q;
    logic [NSRC-1:0]  active;
    logic [REG_W-1:0] slot_word;
    logic [REG_W-1:0] mask_word;

    gpir_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen_i   (bus_wen_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .slot_q  (slot_q),
        .en_q    (en_q),
        .ovr_q   (ovr_q)
    );

    // Only requests that are pending and enabled compete.
    always_comb active = src_req_i & en_q;

    gpir_select #(.VEC_BASE(VEC_BASE)) u_sel (
        .slot_i   (slot_q),
        .active_i (active),
        .ovr_i    (ovr_q),
        .vec_o    (vec_o)
    );

    // Core request follows a non-zero vector.
    always_comb irq_o = (vec_o != '0);

    // Pack slot codes and enables into their register images.
    always_comb begin
        slot_word = '0;
        mask_word = '0;
        for (int p = 0; p < NSRC; p++) slot_word[slot_lsb(p) +: CODE_W] = slot_q[p];
        for (int n = 0; n < NSRC; n++) mask_word[REG_W-1-n] = en_q[n];
    end

    // Read mux of the register bus.
    always_comb begin
        case (grp_addr_e'(bus_addr_i))
            A_SLOT:  bus_rdata_o = slot_word;
            A_CFG:   bus_rdata_o = {1'b0, ovr_q, 24'b0};
            A_MASK:  bus_rdata_o = mask_word;
            A_VEC:   bus_rdata_o = {25'b0, vec_o};
            default: bus_rdata_o = '0;
        endcase
    end

    // R4: a non-zero vector always names an active source.
    a_r4_winner_is_active: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != '0) |-> active[3'(vec_o - BASE)]);

    // R7: the vector is 0 or lies inside the group's range.
    a_r7_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o == '0) || (vec_o >= BASE && vec_o <= BASE + 7'd7));

    // R6: an active in-group override source always wins.
    a_r6_override_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q >= BASE && ovr_q <= BASE + 7'd7 && active[3'(ovr_q - BASE)])
        |-> (vec_o == ovr_q));

    // R3: with no enabled request, no vector is presented.
    a_r3_no_enabled_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (vec_o == '0));

endmodule

// File: tb/gpir_top_tb.sv
module gpir_top_tb;

    localparam int BASE = 32;

    typedef struct packed {
        logic [23:0] codes;   // octal digits: position 0 first
        logic [7:0]  en;      // bit n enables source n
        logic [6:0]  ovr;
        logic [7:0]  req;
        logic [6:0]  exp;
    } vrow_t;

    localparam int NROW = 14;
    localparam vrow_t ROWS [NROW] = '{
        '{24'o01234567, 8'hFF, 7'd0,   8'hA0, 7'd37},  // R4 identity
        '{24'o01234567, 8'hFF, 7'd0,   8'h00, 7'd0 },  // R7 none
        '{24'o76543210, 8'hFF, 7'd0,   8'hA0, 7'd39},  // R4 reversed
        '{24'o76543210, 8'h7F, 7'd0,   8'hA0, 7'd37},  // R3 mask 7
        '{24'o01234567, 8'h00, 7'd0,   8'hFF, 7'd0 },  // R3 all masked
        '{24'o01234567, 8'hFF, 7'd38,  8'hFF, 7'd38},  // R6 override wins
        '{24'o01234567, 8'hFF, 7'd38,  8'h03, 7'd32},  // R6 override idle
        '{24'o01234567, 8'hBF, 7'd38,  8'h41, 7'd32},  // R6 override disabled
        '{24'o33124567, 8'hFF, 7'd0,   8'h01, 7'd0 },  // R5 unnamed source
        '{24'o33124567, 8'hFF, 7'd0,   8'h09, 7'd35},  // R5 duplicate first
        '{24'o33124567, 8'hFF, 7'd32,  8'h01, 7'd32},  // R6 override unnamed
        '{24'o01234567, 8'hFF, 7'd100, 8'h80, 7'd39},  // R6 out of group high
        '{24'o01234567, 8'hFF, 7'd31,  8'h04, 7'd34},  // R6 out of group low
        '{24'o22222226, 8'hFF, 7'd0,   8'h40, 7'd38}   // R5 last position
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  src_req_i;
    logic [2:0]  bus_addr_i;
    logic        bus_wen_i;
    logic [31:0] bus_wdata_i;
    logic [31:0] bus_rdata_o;
    logic [6:0]  vec_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    gpir_top #(.VEC_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i),
        .bus_addr_i(bus_addr_i), .bus_wen_i(bus_wen_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .vec_o(vec_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] pack(input logic [23:0] codes);
        logic [31:0] r = '0;
        for (int p = 0; p < 8; p++) begin
            int lsb = (p < 4) ? 20 + (3 - p) * 3 : 4 + (7 - p) * 3;
            r[lsb +: 3] = codes[21 - 3 * p +: 3];
        end
        return r;
    endfunction

    function automatic logic [31:0] mask_img(input logic [7:0] en);
        logic [31:0] r = '0;
        for (int n = 0; n < 8; n++) r[31 - n] = en[n];
        return r;
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wen_i = 1'b1;
        @(negedge clk);
        bus_wen_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic check_reset_state();
        rd(3'd0, rv); check("R1 slots", rv, pack(24'o01234567));
        rd(3'd1, rv); check("R1 override", rv, 32'h0);
        rd(3'd2, rv); check("R1 enables", rv, 32'h0);
        rd(3'd3, rv); check("R1 vector", rv, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        #(10 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_req_i = 8'hFF; bus_addr_i = '0;
        bus_wen_i = 1'b0; bus_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // Vector table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NROW; i++) begin
            wr(3'd0, pack(ROWS[i].codes));
            wr(3'd2, mask_img(ROWS[i].en));
            wr(3'd1, {1'b0, ROWS[i].ovr, 24'b0});
            src_req_i = ROWS[i].req;
            #1;
            check($sformatf("R4 row %0d vec", i), {25'b0, vec_o}, {25'b0, ROWS[i].exp});
            check($sformatf("R8 row %0d irq", i), {31'b0, irq_o}, {31'b0, (ROWS[i].exp != 0)});
            rd(3'd3, rv);
            check($sformatf("R7 row %0d reg", i), rv, {25'b0, ROWS[i].exp});
        end

        // R2: read-back keeps only slot bits; R3 and R6 image bits
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, rv); check("R2 slot image", rv, 32'hFFF0_FFF0);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, rv); check("R3 enable image", rv, 32'hFF00_0000);
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, rv); check("R6 override image", rv, 32'h7F00_0000);
        wr(3'd0, pack(24'o01234567)); rd(3'd0, rv); check("R2 identity", rv, 32'h0530_9770);

        // R9: out-of-range positions rejected, in-range replaces one field
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h0000_0508); rd(3'd0, rv); check("R9 pos 8", rv, pack(24'o01234567));
        wr(3'd4, 32'h0000_050F); rd(3'd0, rv); check("R9 pos 15", rv, pack(24'o01234567));
        wr(3'd4, 32'h0000_0007); rd(3'd0, rv); check("R9 pos 7", rv, pack(24'o01234560));
        src_req_i = 8'h80; #1;
        check("R5 source 7 unnamed", {25'b0, vec_o}, 32'h0);

        // R10: vector address is not writable
        wr(3'd0, pack(24'o01234567));
        src_req_i = 8'h30; #1;
        check("R10 before", {25'b0, vec_o}, 32'd36);
        wr(3'd3, 32'hFFFF_FFFF);
        check("R10 vector", {25'b0, vec_o}, 32'd36);
        rd(3'd0, rv); check("R10 slots", rv, pack(24'o01234567));
        rd(3'd2, rv); check("R10 enables", rv, 32'hFF00_0000);
        rd(3'd1, rv); check("R10 override", rv, 32'h0);

        // R7: slot write under pending requests, takes effect after the edge
        @(negedge clk);
        bus_addr_i = 3'd0; bus_wdata_i = pack(24'o76543210); bus_wen_i = 1'b1;
        #1; check("R7 old winner", {25'b0, vec_o}, 32'd36);
        @(negedge clk);
        bus_wen_i = 1'b0;
        #1; check("R7 new winner", {25'b0, vec_o}, 32'd37);

        // R1: reset again mid-run
        src_req_i = 8'hFF;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check_reset_state();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule